// File: doc/BRIEF.md
# Pin Bank Controller with Set/Clear Ports

This block drives a bank of 32 general-purpose pins through a small register interface of address, write enable, write data and read data. Software never rewrites a whole level register. It writes a mask of ones to a set port or to a clear port, and every pin named in the mask takes that level. The same write also switches on the pin's output driver. A third write port switches drivers off again, so the pin returns to high impedance. When read, each of these addresses returns state rather than acting as a port: the driver enables, the programmed levels, or the synchronised pin levels.

The low eight pins can also serve as wake sources. Software loads an enable mask for them. While the sleep input is held, the block compares each enabled pin against the level it had when sleep began, and it raises a single wake output on any difference. Register state is cleared only by the hardware reset. The runtime reset leaves every register alone and only restarts the wake tracking.

Top module: `pinbank_ctrl`

## Requirements
- R1: After hardware reset, reading offset 0x100 and offset 0x108 returns 0, pin_oe and pin_o are all 0, and wake_o is 0.
- R2: A write to offset 0x108 sets the level bit and the driver-enable bit of every pin whose data bit is 1. Bits written as 0 leave both unchanged. The result is visible from the cycle after the write edge.
- R3: A write to offset 0x10C clears the level bit and sets the driver-enable bit of every pin whose data bit is 1. Bits written as 0 leave both unchanged.
- R4: A write to offset 0x100 clears the driver-enable bit of every pin whose data bit is 1. The levels and the other enables are unchanged.
- R5: Read data follows the address in the same cycle. Offset 0x100 returns the driver enables (bit n = 1 means pin n is driven). Offset 0x108 returns the programmed levels. Offset 0x10C and every unmapped offset return 0.
- R6: pin_o always equals the programmed level register and pin_oe always equals the driver-enable register.
- R7: Reading offset 0x110 returns pin_i as it stood two clock edges earlier, through a two-stage synchroniser, for driven and undriven pins alike.
- R8: A write to offset 0x110 loads bits 7:0 of the write data as the wake-enable mask. Bits 31:8 have no effect.
- R9: wake_o is 0 while sleep is low and in the first cycle of sleep. From the next cycle on, it is 1 exactly when some enabled pin among 7:0 has a synchronised level that differs from its level at sleep entry. Disabled pins and pins 31:8 never cause a wake.
- R10: The runtime reset leaves the levels, the enables and the wake mask untouched. A write in the same cycle still takes effect. wake_o is 0 in the cycle after the reset, and the entry levels are captured again.
- R11: A write cycle with wr_en low, or a write to an unmapped offset, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst | input | 1 | Synchronous active-high hardware reset; clears all state |
| rt_rst | input | 1 | Synchronous active-high runtime reset; restarts wake tracking only |
| addr | input | 12 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| sleep | input | 1 | High while the system sleeps |
| pin_i | input | 32 | Asynchronous pin levels |
| pin_o | output | 32 | Level driven on each pin |
| pin_oe | output | 32 | Driver enable per pin, 1 = driven |
| wake_o | output | 1 | Wake request |

## Verification
Two functions can meet in one clock edge: a register write and the runtime reset. A directed step raises rt_rst in the same cycle as a set-port write while the system sleeps with a wake pending. The step then checks three things: the written pins carry the new level and enable, the untouched registers keep their values, and the wake output drops for a cycle and stays low against the recaptured entry levels. A second case places a sleep-time pin change beside writes to the wake mask. Bits above 7 in the mask write and changes on disabled pins are then judged at wake_o.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int PB_PINS   = 32;
    localparam int PB_ADDR_W = 12;
    localparam int PB_WAKE_N = 8;

    localparam logic [PB_ADDR_W-1:0] OFS_DRV   = 12'h100;
    localparam logic [PB_ADDR_W-1:0] OFS_LVL   = 12'h108;
    localparam logic [PB_ADDR_W-1:0] OFS_LOW   = 12'h10C;
    localparam logic [PB_ADDR_W-1:0] OFS_SENSE = 12'h110;

    typedef logic [PB_PINS-1:0] pin_vec_t;

    typedef enum logic [2:0] {
        WOP_NONE,
        WOP_DRV_OFF,
        WOP_LVL_HIGH,
        WOP_LVL_LOW,
        WOP_WAKE_MASK
    } wr_op_e;

    typedef struct packed {
        pin_vec_t drv;
        pin_vec_t lvl;
    } pin_state_t;

    function automatic wr_op_e decode_write(input logic [PB_ADDR_W-1:0] a,
                                            input logic we);
        wr_op_e op;
        op = WOP_NONE;
        if (we) begin
            case (a)
                OFS_DRV:   op = WOP_DRV_OFF;
                OFS_LVL:   op = WOP_LVL_HIGH;
                OFS_LOW:   op = WOP_LVL_LOW;
                OFS_SENSE: op = WOP_WAKE_MASK;
                default:   op = WOP_NONE;
            endcase
        end
        return op;
    endfunction

    function automatic pin_state_t next_state(input pin_state_t cur,
                                              input wr_op_e op,
                                              input pin_vec_t m);
        pin_state_t nx;
        nx = cur;
        case (op)
            WOP_DRV_OFF:  nx.drv = cur.drv & ~m;
            WOP_LVL_HIGH: begin
                nx.lvl = cur.lvl | m;
                nx.drv = cur.drv | m;
            end
            WOP_LVL_LOW:  begin
                nx.lvl = cur.lvl & ~m;
                nx.drv = cur.drv | m;
            end
            default:      nx = cur;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int NWAKE = PB_WAKE_N
) (
    input  logic             clk,
    input  logic             hw_rst,
    input  wr_op_e           op,
    input  pin_vec_t         wdata,
    output pin_state_t       state,
    output logic [NWAKE-1:0] wake_mask
);

    pin_state_t state_q;
    logic [NWAKE-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (hw_rst) begin
            state_q <= '0;
            mask_q  <= '0;
        end else begin
            state_q <= next_state(state_q, op, wdata);
            if (op == WOP_WAKE_MASK) begin
                mask_q <= wdata[NWAKE-1:0];
            end
        end
    end

    assign state     = state_q;
    assign wake_mask = mask_q;

endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         hw_rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (hw_rst) stg[s] <= '0;
                    else        stg[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (hw_rst) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pinbank_wake.sv
module pinbank_wake #(
    parameter int NWAKE = 8
) (
    input  logic             clk,
    input  logic             hw_rst,
    input  logic             rt_rst,
    input  logic             sleep,
    input  logic [NWAKE-1:0] levels,
    input  logic [NWAKE-1:0] mask,
    output logic             wake
);

    logic             asleep_q;
    logic [NWAKE-1:0] entry_q;
    logic [NWAKE-1:0] moved;

    always_ff @(posedge clk) begin
        if (hw_rst || rt_rst) begin
            asleep_q <= 1'b0;
            entry_q  <= '0;
        end else begin
            asleep_q <= sleep;
            if (sleep && !asleep_q) begin
                entry_q <= levels;
            end
        end
    end

    assign moved = (levels ^ entry_q) & mask;
    assign wake  = sleep && asleep_q && (|moved);

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
(
    input  logic                 clk,
    input  logic                 hw_rst,
    input  logic                 rt_rst,
    input  logic [PB_ADDR_W-1:0] addr,
    input  logic                 wr_en,
    input  logic [PB_PINS-1:0]   wdata,
    output logic [PB_PINS-1:0]   rdata,
    input  logic                 sleep,
    input  logic [PB_PINS-1:0]   pin_i,
    output logic [PB_PINS-1:0]   pin_o,
    output logic [PB_PINS-1:0]   pin_oe,
    output logic                 wake_o
);

    localparam int SYNC_STAGES = 2;

    wr_op_e              op;
    pin_state_t          state;
    logic [PB_WAKE_N-1:0] wake_mask;
    pin_vec_t            pin_sync;

    assign op = decode_write(addr, wr_en);

    pinbank_regs #(.NWAKE(PB_WAKE_N)) u_regs (
        .clk       (clk),
        .hw_rst    (hw_rst),
        .op        (op),
        .wdata     (wdata),
        .state     (state),
        .wake_mask (wake_mask)
    );

    pinbank_sync #(.W(PB_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .hw_rst (hw_rst),
        .d      (pin_i),
        .q      (pin_sync)
    );

    pinbank_wake #(.NWAKE(PB_WAKE_N)) u_wake (
        .clk    (clk),
        .hw_rst (hw_rst),
        .rt_rst (rt_rst),
        .sleep  (sleep),
        .levels (pin_sync[PB_WAKE_N-1:0]),
        .mask   (wake_mask),
        .wake   (wake_o)
    );

    always_comb begin
        case (addr)
            OFS_DRV:   rdata = state.drv;
            OFS_LVL:   rdata = state.lvl;
            OFS_SENSE: rdata = pin_sync;
            default:   rdata = '0;
        endcase
    end

    assign pin_o  = state.lvl;
    assign pin_oe = state.drv;

endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk
    import pinbank_pkg::*;
(
    input logic                 clk,
    input logic                 hw_rst,
    input logic                 rt_rst,
    input logic [PB_ADDR_W-1:0] addr,
    input logic                 wr_en,
    input logic [PB_PINS-1:0]   wdata,
    input logic [PB_PINS-1:0]   rdata,
    input logic                 sleep,
    input logic [PB_PINS-1:0]   pin_o,
    input logic [PB_PINS-1:0]   pin_oe,
    input logic                 wake_o
);

    // R2
    property p_set_port;
        @(posedge clk) disable iff (hw_rst)
        (wr_en && addr == OFS_LVL) |=>
            (((pin_o & $past(wdata)) == $past(wdata)) &&
             ((pin_oe & $past(wdata)) == $past(wdata)));
    endproperty
    set_port_chk: assert property (p_set_port);

    // R3
    property p_low_port;
        @(posedge clk) disable iff (hw_rst)
        (wr_en && addr == OFS_LOW) |=>
            (((pin_o & $past(wdata)) == '0) &&
             ((pin_oe & $past(wdata)) == $past(wdata)));
    endproperty
    low_port_chk: assert property (p_low_port);

    // R4
    property p_drv_off;
        @(posedge clk) disable iff (hw_rst)
        (wr_en && addr == OFS_DRV) |=>
            (((pin_oe & $past(wdata)) == '0) && $stable(pin_o));
    endproperty
    drv_off_chk: assert property (p_drv_off);

    // R11
    property p_idle_hold;
        @(posedge clk) disable iff (hw_rst)
        !wr_en |=> ($stable(pin_o) && $stable(pin_oe));
    endproperty
    idle_hold_chk: assert property (p_idle_hold);

    // R9
    property p_awake_quiet;
        @(posedge clk) disable iff (hw_rst)
        !sleep |-> !wake_o;
    endproperty
    awake_quiet_chk: assert property (p_awake_quiet);

    // R10
    property p_rt_restart;
        @(posedge clk) disable iff (hw_rst)
        rt_rst |=> !wake_o;
    endproperty
    rt_restart_chk: assert property (p_rt_restart);

    // R5
    always_comb begin
        if (!hw_rst && addr == OFS_DRV) begin
            drv_read_chk: assert (rdata == pin_oe);
        end
        if (!hw_rst && addr == OFS_LVL) begin
            lvl_read_chk: assert (rdata == pin_o);
        end
    end

endmodule

bind pinbank_ctrl pinbank_ctrl_chk u_chk (
    .clk    (clk),
    .hw_rst (hw_rst),
    .rt_rst (rt_rst),
    .addr   (addr),
    .wr_en  (wr_en),
    .wdata  (wdata),
    .rdata  (rdata),
    .sleep  (sleep),
    .pin_o  (pin_o),
    .pin_oe (pin_oe),
    .wake_o (wake_o)
);

// File: tb/pinbank_ctrl_bench.sv
module pinbank_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        hw_rst = 1'b1;
    logic        rt_rst = 1'b0;
    logic [11:0] addr = 12'h000;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sleep = 1'b0;
    logic [31:0] pin_i = '0;
    logic [31:0] pin_o;
    logic [31:0] pin_oe;
    logic        wake_o;

    int checks = 0;
    int failures = 0;

    logic [31:0] m_drv = '0;
    logic [31:0] m_lvl = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pinbank_ctrl u_pinbank_ctrl (
        .clk    (clk),
        .hw_rst (hw_rst),
        .rt_rst (rt_rst),
        .addr   (addr),
        .wr_en  (wr_en),
        .wdata  (wdata),
        .rdata  (rdata),
        .sleep  (sleep),
        .pin_i  (pin_i),
        .pin_o  (pin_o),
        .pin_oe (pin_oe),
        .wake_o (wake_o)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic check_eq(input string req, input logic [31:0] act,
                            input logic [31:0] exp);
        check(act === exp, req, act, exp);
    endtask

    // expected state after a write, from R2/R3/R4/R11
    function automatic logic [63:0] model_next(input logic [11:0] a,
                                               input logic we,
                                               input logic [31:0] d,
                                               input logic [31:0] drv,
                                               input logic [31:0] lvl);
        logic [31:0] nd, nl;
        nd = drv; nl = lvl;
        if (we) begin
            if (a == 12'h100) nd = drv & ~d;
            if (a == 12'h108) begin nl = lvl | d; nd = drv | d; end
            if (a == 12'h10C) begin nl = lvl & ~d; nd = drv | d; end
        end
        return {nd, nl};
    endfunction

    task automatic do_write(input logic [11:0] a, input logic [31:0] d,
                            input logic we);
        logic [63:0] nx;
        @(negedge clk);
        addr = a; wdata = d; wr_en = we;
        nx = model_next(a, we, d, m_drv, m_lvl);
        m_drv = nx[63:32];
        m_lvl = nx[31:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_at(input logic [11:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic check_state(input string tag);
        logic [31:0] v;
        read_at(12'h100, v);
        check_eq({tag, " R5 drv read"}, v, m_drv);
        read_at(12'h108, v);
        check_eq({tag, " R5 lvl read"}, v, m_lvl);
        check_eq({tag, " R6 pin_oe"}, pin_oe, m_drv);
        check_eq({tag, " R6 pin_o"}, pin_o, m_lvl);
    endtask

    task automatic wait_cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v, p, prev;
        void'($urandom(32'd20240611));

        wait_cycles(3);
        hw_rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        read_at(12'h100, v); check_eq("R1 drv after reset", v, 32'h0);
        read_at(12'h108, v); check_eq("R1 lvl after reset", v, 32'h0);
        check_eq("R1 pin_oe", pin_oe, 32'h0);
        check_eq("R1 pin_o", pin_o, 32'h0);
        check_eq("R1 wake_o", {31'h0, wake_o}, 32'h0);

        // directed R2, R3, R4
        do_write(12'h108, 32'hA5A5_0003, 1'b1); check_state("R2 set");
        do_write(12'h10C, 32'h0000_0F01, 1'b1); check_state("R3 low");
        do_write(12'h100, 32'h0000_0003, 1'b1); check_state("R4 drv off");
        do_write(12'h108, 32'hFFFF_FFFF, 1'b1); check_state("R2 all ones");
        do_write(12'h10C, 32'h0000_0000, 1'b1); check_state("R3 zero mask");

        // R5 non-status offsets read 0
        read_at(12'h10C, v); check_eq("R5 low port reads 0", v, 32'h0);
        read_at(12'h104, v); check_eq("R5 unmapped reads 0", v, 32'h0);
        read_at(12'h000, v); check_eq("R5 unmapped low reads 0", v, 32'h0);

        // R11 ignored writes
        do_write(12'h10C, 32'hFFFF_FFFF, 1'b0); check_state("R11 we low");
        do_write(12'h104, 32'hFFFF_FFFF, 1'b1); check_state("R11 unmapped");

        // random mix
        for (int i = 0; i < 300; i++) begin
            int sel;
            logic [31:0] d;
            sel = $urandom_range(0, 4);
            d = $urandom;
            case (sel)
                0: do_write(12'h108, d, 1'b1);
                1: do_write(12'h10C, d, 1'b1);
                2: do_write(12'h100, d, 1'b1);
                3: do_write(12'h108, d, 1'b0);
                default: do_write(12'h114, d, 1'b1);
            endcase
            check_state("R2 R3 R4 R11 random");
        end

        // R7 pin readback, two-edge latency
        prev = pin_i;
        for (int i = 0; i < 40; i++) begin
            p = $urandom;
            @(negedge clk);
            pin_i = p;
            @(negedge clk);
            read_at(12'h110, v); check_eq("R7 one edge still old", v, prev);
            @(negedge clk);
            read_at(12'h110, v); check_eq("R7 two edges new", v, p);
            prev = p;
        end

        // wake scenario
        @(negedge clk); pin_i = 32'h0;
        do_write(12'h110, 32'hFFFF_FF05, 1'b1);   // R8 mask = pins 0 and 2
        wait_cycles(3);
        @(negedge clk); sleep = 1'b1;
        #1; check_eq("R9 entry cycle quiet", {31'h0, wake_o}, 32'h0);
        wait_cycles(3);
        check_eq("R9 no change no wake", {31'h0, wake_o}, 32'h0);
        pin_i = 32'h0000_FF0A;                    // pins 1,3,8..15
        wait_cycles(3);
        check_eq("R8 R9 disabled pins no wake", {31'h0, wake_o}, 32'h0);
        pin_i = 32'h0000_FF0E;                    // pin 2 rises
        wait_cycles(3);
        check_eq("R9 enabled pin wakes", {31'h0, wake_o}, 32'h1);

        // R10 runtime reset together with a write
        rt_rst = 1'b1; addr = 12'h108; wdata = 32'h0000_00F0; wr_en = 1'b1;
        begin
            logic [63:0] nx;
            nx = model_next(12'h108, 1'b1, 32'h0000_00F0, m_drv, m_lvl);
            m_drv = nx[63:32]; m_lvl = nx[31:0];
        end
        @(negedge clk);
        rt_rst = 1'b0; wr_en = 1'b0;
        #1; check_eq("R10 wake dropped", {31'h0, wake_o}, 32'h0);
        check_state("R10 write lands, state kept");
        wait_cycles(3);
        check_eq("R10 baseline recaptured", {31'h0, wake_o}, 32'h0);
        pin_i = 32'h0000_FF0A;                    // pin 2 falls vs new entry
        wait_cycles(3);
        check_eq("R10 R8 mask kept, wakes", {31'h0, wake_o}, 32'h1);
        sleep = 1'b0;
        #1; check_eq("R9 sleep low quiet", {31'h0, wake_o}, 32'h0);

        // R8 mask reload with upper bits only: no wake source
        do_write(12'h110, 32'hFFFF_FF00, 1'b1);
        @(negedge clk); sleep = 1'b1;
        wait_cycles(3);
        pin_i = 32'h0000_00F5;
        wait_cycles(3);
        check_eq("R8 upper bits ignored", {31'h0, wake_o}, 32'h0);
        sleep = 1'b0;

        // R1 hardware reset clears all
        @(negedge clk); hw_rst = 1'b1;
        @(negedge clk); hw_rst = 1'b0;
        m_drv = '0; m_lvl = '0;
        check_state("R1 after second reset");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule